// File: doc/BRIEF.md
# Multi-Thread Gate Control List Scheduler

This block is a time-aware egress gate scheduler. All ports share one table of gate-control timeslots. Each slot holds a duration, a mask of the destination ports it applies to, and an 8-bit mask of the traffic classes it blocks. Up to eight execution threads each walk their own contiguous slice of that table in a loop. While a thread sits on a slot, it closes the blocked classes on every port the slot targets, for as long as the slot's duration.

Software loads the table through a write port while the scheduler is stopped. It then sets up the per-thread table:
- an entry address for each thread;
- an entry delay, counted in 200 ns units after a programmed base time;
- an end index for each thread. The end indices must never decrease from thread 0 to thread 7, and unused threads repeat the last valid end index.

A start command arms the threads. Each active thread starts when the synchronized 64-bit time reaches the base time plus that thread's entry delay. A stop command halts every thread and opens all gates.

Top module: `gcl_sched`

## Requirements
- R1: After reset, `sched_stopped` is 1, `sched_started` is 0, `req_err` is 0, no thread runs, and every bit of `gate_open` is 1 (open).
- R2: A table write is stored only while `sched_stopped` is 1 and `wr_dur` is between 1 and MAX_DELTA (1000) inclusive. Any other write leaves the table unchanged, and `req_err` is 1 in the cycle after the write.
- R3: A start command is rejected if either of two conditions holds. The first is an end index lower than the end index of the previous thread, checked over all eight threads. The second is a zero entry delay on any thread with an index of at most `act_threads`. A rejected start leaves the status bits as they were and sets `req_err` to 1 in the next cycle. An accepted start sets `sched_started` and clears `sched_stopped`.
- R4: After an accepted start from the stopped state, thread i (with i at most `act_threads`) begins on the first clock edge at which `sync_time` >= `sched_base` + 200 × entry delay of thread i. From the next cycle, its entry slot drives the gates.
- R5: A slot stays current for exactly duration × CYC_PER_UNIT clock cycles (20 by default, so one unit is 200 ns at 100 MHz).
- R6: After its end index, a thread returns to its entry address. Otherwise it advances to the next index.
- R7: Threads with an index above `act_threads` never run.
- R8: `gate_open[p*8+c]` is 0 exactly when some running thread's current slot has port bit p set and blocked-class bit c set. When several threads target the same port, their blocked masks are ORed. A port that no running thread targets is fully open.
- R9: A stop command clears `sched_started`, sets `sched_stopped`, halts every thread and opens all gates from the next cycle.
- R10: When start and stop are asserted in the same cycle, the stop takes effect and the start is neither applied nor reported as an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_time | input | 64 | Synchronized time in ns |
| sched_base | input | 64 | Programmed schedule base time in ns |
| start_cmd | input | 1 | Start command pulse |
| stop_cmd | input | 1 | Stop command pulse |
| act_threads | input | 3 | Number of used threads minus one |
| ep_addr_vec | input | 48 | Entry slot address per thread, 6 bits each, thread 0 in bits [5:0] |
| ep_delay_vec | input | 128 | Entry delay per thread in 200 ns units, 16 bits each |
| end_idx_vec | input | 48 | End slot index per thread, 6 bits each |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 6 | Table write address |
| wr_dur | input | 10 | Slot duration in 200 ns units |
| wr_ports | input | 4 | Slot destination-port mask |
| wr_blocked | input | 8 | Slot blocked traffic-class mask |
| gate_open | output | 32 | Gate state, bit p*8+c for port p, class c; 1 means open |
| sched_started | output | 1 | Schedule started status |
| sched_stopped | output | 1 | Schedule stopped status |
| thread_run | output | 8 | Per-thread running flags |
| req_err | output | 1 | Rejected write or start, valid for one cycle |

## Verification
The first run uses two threads with different entry delays and slices of different lengths. The slots have mixed durations, and both threads target the same port. This separates a wrong start instant from a wrong slot length, a wrong wrap point and a wrong merge of blocked masks.

A second run adds a third thread with a single-slot slice and a long entry delay. This exposes errors in how the active-thread count is decoded and in wrapping a slice of length one.

Two kinds of requests are sent that must be rejected. Table writes arrive while running and with out-of-range durations, and one of them targets a slot in use, so a write that was wrongly accepted would show on the gates. Starts arrive with non-monotonic end indices and with a zero entry delay. A start and a stop in the same cycle confirm that the stop takes precedence.

// File: rtl/gcl_pkg.sv
package gcl_pkg;
    localparam int GCL_THREADS = 8;
    localparam int GCL_PORTS   = 4;
    localparam int GCL_TC      = 8;
    localparam int GCL_DEPTH   = 64;
    localparam int GCL_IDX_W   = $clog2(GCL_DEPTH);
    localparam int GCL_DUR_W   = 10;
    localparam int GCL_EPD_W   = 16;
    localparam int GCL_ACT_W   = $clog2(GCL_THREADS);
    localparam int GCL_REM_W   = GCL_DUR_W + 16;

    typedef logic [GCL_IDX_W-1:0] idx_t;

    typedef struct packed {
        logic [GCL_DUR_W-1:0] dur;
        logic [GCL_PORTS-1:0] ports;
        logic [GCL_TC-1:0]    blocked;
    } slot_t;

    // Thread table legality: non-decreasing end indices, nonzero entry delay on used threads
    function automatic logic cfg_legal(
        input logic [GCL_THREADS*GCL_IDX_W-1:0] ends,
        input logic [GCL_THREADS*GCL_EPD_W-1:0] delays,
        input logic [GCL_ACT_W-1:0]             act
    );
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < GCL_THREADS; i++) begin
            if (i > 0 && ends[i*GCL_IDX_W +: GCL_IDX_W] < ends[(i-1)*GCL_IDX_W +: GCL_IDX_W])
                ok = 1'b0;
            if (GCL_ACT_W'(i) <= act && delays[i*GCL_EPD_W +: GCL_EPD_W] == '0)
                ok = 1'b0;
        end
        return ok;
    endfunction
endpackage

// File: rtl/gcl_slot_table.sv
module gcl_slot_table
    import gcl_pkg::*;
#(
    parameter int MAX_DELTA = 1000,
    parameter int NRD       = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  wr_allow,
    input  idx_t  wr_addr,
    input  slot_t wr_slot,
    output logic  wr_ok,
    input  idx_t  rd_addr [NRD],
    output slot_t rd_slot [NRD]
);
    slot_t mem [GCL_DEPTH];

    assign wr_ok = wr_en && wr_allow && (wr_slot.dur != '0) &&
                   (int'(wr_slot.dur) <= MAX_DELTA);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < GCL_DEPTH; k++) mem[k] <= '0;
        end else if (wr_ok) begin
            mem[wr_addr] <= wr_slot;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_slot[r] = mem[rd_addr[r]];
    end
endmodule

// File: rtl/gcl_thread.sv
module gcl_thread
    import gcl_pkg::*;
#(
    parameter int CYC_PER_UNIT = 20,
    parameter int UNIT_NS      = 200
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 halt,
    input  logic                 arm_set,
    input  logic                 enabled,
    input  logic [63:0]          sync_time,
    input  logic [63:0]          sched_base,
    input  logic [GCL_EPD_W-1:0] ep_delay,
    input  idx_t                 ep_addr,
    input  idx_t                 end_idx,
    input  logic [GCL_DUR_W-1:0] nxt_dur,
    output idx_t                 nxt_idx,
    output idx_t                 cur_idx,
    output logic                 running
);
    logic                 armed_q, run_q;
    idx_t                 idx_q;
    logic [GCL_REM_W-1:0] rem_q, load_cyc;
    logic                 due, step;

    assign due  = sync_time >= (sched_base + 64'(ep_delay) * 64'(UNIT_NS));
    assign step = run_q && (rem_q == '0);

    always_comb begin
        if (!run_q)
            nxt_idx = ep_addr;
        else if (step)
            nxt_idx = (idx_q >= end_idx) ? ep_addr : idx_q + idx_t'(1);
        else
            nxt_idx = idx_q;
    end

    assign load_cyc = (nxt_dur == '0) ? '0
                    : GCL_REM_W'(nxt_dur) * GCL_REM_W'(CYC_PER_UNIT) - GCL_REM_W'(1);

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            armed_q <= 1'b0;
            run_q   <= 1'b0;
            idx_q   <= '0;
            rem_q   <= '0;
        end else begin
            if (arm_set) armed_q <= 1'b1;
            if (armed_q && enabled && !run_q && due) begin
                run_q   <= 1'b1;
                armed_q <= 1'b0;
                idx_q   <= nxt_idx;
                rem_q   <= load_cyc;
            end else if (run_q) begin
                if (step) begin
                    idx_q <= nxt_idx;
                    rem_q <= load_cyc;
                end else begin
                    rem_q <= rem_q - GCL_REM_W'(1);
                end
            end
        end
    end

    assign cur_idx = idx_q;
    assign running = run_q;
endmodule

// File: rtl/gcl_gate_merge.sv
module gcl_gate_merge
    import gcl_pkg::*;
(
    input  logic [GCL_THREADS-1:0]        running,
    input  slot_t                         cur_slot [GCL_THREADS],
    output logic [GCL_PORTS*GCL_TC-1:0]   gate_open
);
    for (genvar p = 0; p < GCL_PORTS; p++) begin : g_port
        logic [GCL_TC-1:0] shut;
        always_comb begin
            shut = '0;
            for (int t = 0; t < GCL_THREADS; t++)
                if (running[t] && cur_slot[t].ports[p])
                    shut = shut | cur_slot[t].blocked;
        end
        assign gate_open[p*GCL_TC +: GCL_TC] = ~shut;
    end
endmodule

// File: rtl/gcl_sched.sv
module gcl_sched
    import gcl_pkg::*;
#(
    parameter int CYC_PER_UNIT = 20,
    parameter int UNIT_NS      = 200,
    parameter int MAX_DELTA    = 1000
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [63:0]                      sync_time,
    input  logic [63:0]                      sched_base,
    input  logic                             start_cmd,
    input  logic                             stop_cmd,
    input  logic [GCL_ACT_W-1:0]             act_threads,
    input  logic [GCL_THREADS*GCL_IDX_W-1:0] ep_addr_vec,
    input  logic [GCL_THREADS*GCL_EPD_W-1:0] ep_delay_vec,
    input  logic [GCL_THREADS*GCL_IDX_W-1:0] end_idx_vec,
    input  logic                             wr_en,
    input  logic [GCL_IDX_W-1:0]             wr_addr,
    input  logic [GCL_DUR_W-1:0]             wr_dur,
    input  logic [GCL_PORTS-1:0]             wr_ports,
    input  logic [GCL_TC-1:0]                wr_blocked,
    output logic [GCL_PORTS*GCL_TC-1:0]      gate_open,
    output logic                             sched_started,
    output logic                             sched_stopped,
    output logic [GCL_THREADS-1:0]           thread_run,
    output logic                             req_err
);
    localparam int NRD = 2 * GCL_THREADS;

    logic  cfg_ok, start_ok, arm_set, wr_ok;
    logic  started_q, stopped_q, err_q;
    slot_t wr_slot;
    idx_t  rd_addr [NRD];
    slot_t rd_slot [NRD];
    slot_t cur_slot [GCL_THREADS];

    assign cfg_ok   = cfg_legal(end_idx_vec, ep_delay_vec, act_threads);
    assign start_ok = start_cmd && !stop_cmd && cfg_ok;
    assign arm_set  = start_ok && !started_q;
    assign wr_slot  = '{dur: wr_dur, ports: wr_ports, blocked: wr_blocked};

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b0;
            stopped_q <= 1'b1;
            err_q     <= 1'b0;
        end else begin
            err_q <= (wr_en && !wr_ok) || (start_cmd && !stop_cmd && !cfg_ok);
            if (stop_cmd) begin
                started_q <= 1'b0;
                stopped_q <= 1'b1;
            end else if (start_ok) begin
                started_q <= 1'b1;
                stopped_q <= 1'b0;
            end
        end
    end

    gcl_slot_table #(.MAX_DELTA(MAX_DELTA), .NRD(NRD)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_allow (stopped_q),
        .wr_addr  (wr_addr),
        .wr_slot  (wr_slot),
        .wr_ok    (wr_ok),
        .rd_addr  (rd_addr),
        .rd_slot  (rd_slot)
    );

    for (genvar t = 0; t < GCL_THREADS; t++) begin : g_thr
        idx_t nxt_i, cur_i;
        gcl_thread #(.CYC_PER_UNIT(CYC_PER_UNIT), .UNIT_NS(UNIT_NS)) u_thr (
            .clk        (clk),
            .rst        (rst),
            .halt       (stop_cmd),
            .arm_set    (arm_set),
            .enabled    (GCL_ACT_W'(t) <= act_threads),
            .sync_time  (sync_time),
            .sched_base (sched_base),
            .ep_delay   (ep_delay_vec[t*GCL_EPD_W +: GCL_EPD_W]),
            .ep_addr    (ep_addr_vec[t*GCL_IDX_W +: GCL_IDX_W]),
            .end_idx    (end_idx_vec[t*GCL_IDX_W +: GCL_IDX_W]),
            .nxt_dur    (rd_slot[2*t].dur),
            .nxt_idx    (nxt_i),
            .cur_idx    (cur_i),
            .running    (thread_run[t])
        );
        assign rd_addr[2*t]   = nxt_i;
        assign rd_addr[2*t+1] = cur_i;
        assign cur_slot[t]    = rd_slot[2*t+1];
    end

    gcl_gate_merge u_merge (
        .running   (thread_run),
        .cur_slot  (cur_slot),
        .gate_open (gate_open)
    );

    assign sched_started = started_q;
    assign sched_stopped = stopped_q;
    assign req_err       = err_q;
endmodule

// File: rtl/gcl_sched_chk.sv
module gcl_sched_chk
    import gcl_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en,
    input logic                        start_cmd,
    input logic                        stop_cmd,
    input logic [GCL_ACT_W-1:0]        act_threads,
    input logic [GCL_PORTS*GCL_TC-1:0] gate_open,
    input logic [GCL_THREADS-1:0]      thread_run,
    input logic                        sched_started,
    input logic                        sched_stopped,
    input logic                        req_err
);
    logic [GCL_THREADS:0] used_mask;
    assign used_mask = ((GCL_THREADS+1)'(2) << act_threads) - (GCL_THREADS+1)'(1);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (sched_stopped && !sched_started && thread_run == '0 && !req_err));

    p_write_blocked_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sched_stopped) |=> req_err);

    p_status_excl_r3: assert property (@(posedge clk) disable iff (rst)
        sched_started != sched_stopped);

    p_run_needs_start_r4: assert property (@(posedge clk) disable iff (rst)
        (thread_run != '0) |-> sched_started);

    p_unused_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (thread_run & ~used_mask[GCL_THREADS-1:0]) == '0);

    p_idle_open_r8: assert property (@(posedge clk) disable iff (rst)
        (thread_run == '0) |-> (&gate_open));

    p_stop_halts_r9: assert property (@(posedge clk) disable iff (rst)
        stop_cmd |=> (thread_run == '0 && sched_stopped && !sched_started));

    p_stop_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (start_cmd && stop_cmd) |=> (sched_stopped && !req_err));
endmodule

bind gcl_sched gcl_sched_chk u_chk (.*);

// File: tb/sim_gcl_sched.sv
module sim_gcl_sched;
    import gcl_pkg::*;

    logic clk = 0;
    logic rst = 1;
    logic [63:0] sync_time = 0;
    logic [63:0] sched_base = 0;
    logic start_cmd = 0, stop_cmd = 0;
    logic [2:0] act_threads = 0;
    logic [47:0] ep_addr_vec = 0;
    logic [127:0] ep_delay_vec = 0;
    logic [47:0] end_idx_vec = 0;
    logic wr_en = 0;
    logic [5:0] wr_addr = 0;
    logic [9:0] wr_dur = 0;
    logic [3:0] wr_ports = 0;
    logic [7:0] wr_blocked = 0;
    logic [31:0] gate_open;
    logic sched_started, sched_stopped, req_err;
    logic [7:0] thread_run;

    gcl_sched u0 (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    string phase = "R1";
    bit seen_edge = 0;
    bit done = 0;

    // behavioural reference
    int m_dur[64], m_ports[64], m_blk[64];
    bit m_started, m_stopped, m_err;
    bit m_run[8], m_arm[8];
    int m_idx[8];
    longint m_rem[8];
    int c_addr[8], c_delay[8], c_end[8];

    function automatic longint cyc_of(int d);
        return (d == 0) ? 1 : longint'(d) * 20;
    endfunction

    function automatic logic [31:0] model_gates();
        logic [31:0] g;
        g = '1;
        for (int t = 0; t < 8; t++)
            if (m_run[t])
                for (int p = 0; p < 4; p++)
                    if (m_ports[m_idx[t]][p])
                        for (int c = 0; c < 8; c++)
                            if (m_blk[m_idx[t]][c]) g[p*8+c] = 1'b0;
        return g;
    endfunction

    task automatic push_cfg();
        for (int t = 0; t < 8; t++) begin
            ep_addr_vec[t*6 +: 6]    = 6'(c_addr[t]);
            ep_delay_vec[t*16 +: 16] = 16'(c_delay[t]);
            end_idx_vec[t*6 +: 6]    = 6'(c_end[t]);
        end
    endtask

    always @(posedge clk) begin
        seen_edge <= 1;
        if (rst) begin
            m_started = 0; m_stopped = 1; m_err = 0;
            for (int t = 0; t < 8; t++) begin
                m_run[t] = 0; m_arm[t] = 0; m_idx[t] = 0; m_rem[t] = 0;
            end
            for (int k = 0; k < 64; k++) begin
                m_dur[k] = 0; m_ports[k] = 0; m_blk[k] = 0;
            end
        end else begin
            bit okc, wgood, sgood, was_started;
            okc = 1;
            for (int t = 1; t < 8; t++) if (c_end[t] < c_end[t-1]) okc = 0;
            for (int t = 0; t <= int'(act_threads); t++) if (c_delay[t] == 0) okc = 0;
            wgood = wr_en && m_stopped && wr_dur != 0 && int'(wr_dur) <= 1000;
            sgood = start_cmd && !stop_cmd && okc;
            was_started = m_started;
            for (int t = 0; t < 8; t++) begin
                if (stop_cmd) begin
                    m_run[t] = 0; m_arm[t] = 0;
                end else begin
                    bit old_arm;
                    old_arm = m_arm[t];
                    if (sgood && !was_started) m_arm[t] = 1;
                    if (old_arm && t <= int'(act_threads) && !m_run[t] &&
                        sync_time >= sched_base + 64'(c_delay[t]) * 200) begin
                        m_run[t] = 1; m_arm[t] = 0;
                        m_idx[t] = c_addr[t];
                        m_rem[t] = cyc_of(m_dur[m_idx[t]]) - 1;
                    end else if (m_run[t]) begin
                        if (m_rem[t] == 0) begin
                            m_idx[t] = (m_idx[t] >= c_end[t]) ? c_addr[t] : m_idx[t] + 1;
                            m_rem[t] = cyc_of(m_dur[m_idx[t]]) - 1;
                        end else m_rem[t]--;
                    end
                end
            end
            if (wgood) begin
                m_dur[wr_addr] = int'(wr_dur);
                m_ports[wr_addr] = int'(wr_ports);
                m_blk[wr_addr] = int'(wr_blocked);
            end
            m_err = (wr_en && !wgood) || (start_cmd && !stop_cmd && !okc);
            if (stop_cmd) begin m_started = 0; m_stopped = 1; end
            else if (sgood) begin m_started = 1; m_stopped = 0; end
        end
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        sync_time <= sync_time + 10;
        if (seen_edge && !done) begin
            logic [7:0] mr;
            for (int t = 0; t < 8; t++) mr[t] = m_run[t];
            chk(gate_open == model_gates(), phase, gate_open, model_gates());
            chk(thread_run == mr, phase, thread_run, mr);
            chk({sched_started, sched_stopped, req_err} == {m_started, m_stopped, m_err},
                phase, {sched_started, sched_stopped, req_err}, {m_started, m_stopped, m_err});
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wslot(int a, int d, int p, int b);
        wr_en = 1; wr_addr = 6'(a); wr_dur = 10'(d); wr_ports = 4'(p); wr_blocked = 8'(b);
        cyc(1);
        wr_en = 0;
    endtask

    task automatic pulse_start();
        start_cmd = 1; cyc(1); start_cmd = 0;
    endtask

    task automatic pulse_stop();
        stop_cmd = 1; cyc(1); stop_cmd = 0;
    endtask

    initial begin
        for (int t = 0; t < 8; t++) begin c_addr[t] = 0; c_delay[t] = 1; c_end[t] = 0; end
        push_cfg();
        cyc(3);
        rst = 0;
        cyc(1);
        phase = "R1";
        chk(sched_stopped && !sched_started, "R1", {sched_started, sched_stopped}, 2'b01);
        chk(gate_open == '1, "R1", gate_open, 32'hFFFF_FFFF);

        phase = "R2";
        wslot(0, 1, 4'b0011, 8'h81);
        wslot(1, 2, 4'b0001, 8'h0F);
        wslot(2, 1, 4'b0010, 8'hF0);
        wslot(3, 2, 4'b0010, 8'h03);
        wslot(4, 1, 4'b1000, 8'hFF);
        wslot(5, 3, 4'b0100, 8'h55);
        chk(req_err == 0, "R2", req_err, 0);
        wslot(0, 0, 4'b1111, 8'hFF);
        chk(req_err == 1, "R2", req_err, 1);
        wslot(0, 1010, 4'b1111, 8'hFF);
        chk(req_err == 1, "R2", req_err, 1);

        phase = "R3";
        act_threads = 1;
        c_addr[0] = 0; c_end[0] = 2; c_delay[0] = 1;
        c_addr[1] = 3; c_end[1] = 1; c_delay[1] = 3;
        for (int t = 2; t < 8; t++) begin c_addr[t] = 0; c_end[t] = 4; c_delay[t] = 0; end
        push_cfg();
        pulse_start();
        chk(req_err == 1 && sched_stopped, "R3", {req_err, sched_stopped}, 2'b11);
        c_end[1] = 4; c_delay[1] = 0; push_cfg();
        pulse_start();
        chk(req_err == 1 && !sched_started, "R3", {req_err, sched_started}, 2'b10);
        c_delay[1] = 3; push_cfg();

        phase = "R4";
        sched_base = sync_time + 500;
        pulse_start();
        chk(sched_started && !req_err, "R3", {sched_started, req_err}, 2'b10);
        cyc(120);
        phase = "R5/R6/R8";
        cyc(400);
        phase = "R2";
        wslot(0, 5, 4'b1111, 8'hFF);
        chk(req_err == 1, "R2", req_err, 1);
        cyc(60);
        phase = "R9";
        pulse_stop();
        chk(sched_stopped && thread_run == 0 && gate_open == '1, "R9",
            {sched_stopped, thread_run}, 9'h100);

        phase = "R10";
        start_cmd = 1; stop_cmd = 1; cyc(1); start_cmd = 0; stop_cmd = 0;
        chk(sched_stopped && !req_err, "R10", {sched_stopped, req_err}, 2'b10);

        phase = "R7";
        act_threads = 2;
        c_addr[2] = 5; c_end[2] = 5; c_delay[2] = 6;
        for (int t = 3; t < 8; t++) begin c_end[t] = 5; c_delay[t] = 0; end
        push_cfg();
        sched_base = sync_time + 300;
        pulse_start();
        cyc(150);
        chk(thread_run[7:3] == 0 && thread_run[2] == 1, "R7", thread_run, 8'h07);
        cyc(300);
        pulse_stop();
        cyc(5);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        done = 1;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule